// File: doc/BRIEF.md
# Safety Error Hub

The safety error hub gathers a parameterised vector of safety event inputs into one place and reports them on a single active-low external error pin and on two interrupt lines, one for high-priority events and one for low-priority events. Software programs the block through a small word-wide register port. For each event it chooses whether the input is captured as a level or as a sticky pulse, whether the event is routed to the high-priority or the low-priority path, and whether the event is enabled at all.

The external pin is driven by every enabled high-priority event. Once the pin asserts, it holds for a programmed minimum time. Software can force either path to exercise the downstream handling. The routing, enable and pin-time settings are stored twice, and any disagreement between the two copies is treated as a high-priority error. A test control lets software freeze the second copy so that this check can be exercised.

The event count scales through `NUM_EVT`, which must be a multiple of 32 and is at most 1024. Event inputs are expected to be synchronous to `clk_i`.

Top module: `safety_err_hub`

## Requirements
- R1: An event whose mode bit is 0 (bank 1, bit = event index mod 32) is a level event. Its status bit (bank 4) equals the input as sampled at the previous clock edge. Writing 1 to a level status bit has no effect.
- R2: An event whose mode bit is 1 is a pulse event. A high input sets its status bit, which stays set until software writes 1 to it in bank 4. When a set and a clear occur in the same cycle, the set wins.
- R3: Each enabled event with status set drives `irq_hi_o` when its priority bit (bank 2) is 1, and drives `irq_lo_o` when that bit is 0.
- R4: An event whose enable bit (bank 3) is 0 affects neither interrupt nor the pin. Its raw status is still captured, and it takes effect as soon as the event is enabled.
- R5: `err_pin_no` is active low. It goes low one clock after `irq_hi_o` goes high while the pin is idle.
- R6: Once low, the pin stays low for at least PIN_MIN+1 cycles, where PIN_MIN is global register 1. It returns high only after that time has elapsed and the high-priority cause has gone.
- R7: Global register 0 bit 0 forces the high-priority path (the interrupt and the pin). Bit 1 forces `irq_lo_o`.
- R8: Priority, enable and PIN_MIN are held in two copies. A difference between the copies sets state bit 1 and raises the high-priority path. While global register 0 bit 2 is set, writes update only the first copy. A write made with bit 2 clear restores agreement.
- R9: The register address is {bank[2:0], index[IDX_W-1:0]}. Event banks select the 32-event word by index, so event e lives in word e/32. Global bank indices are 0 for control, 1 for PIN_MIN and 2 for read-only state (bit0 pin active, bit1 copy mismatch, bit2 irq_hi, bit3 irq_lo).
- R10: After reset, all modes, priorities, enables, status bits and control bits are 0, PIN_MIN is 8, the pin is high and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Safety event inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3+IDX_W | Register address {bank, index} |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| irq_hi_o | output | 1 | High-priority interrupt |
| irq_lo_o | output | 1 | Low-priority interrupt |
| err_pin_no | output | 1 | External error pin, active low |

## Verification
A corrupted status bit shows on the interrupt one cycle after the input edge, and on the pin one cycle after that. A stuck or lost pulse capture therefore shows up at the ports within two clocks. A miscounting pin timer shows up as a low period that is shorter or longer than PIN_MIN+1 cycles, which the bench measures cycle by cycle. A divergence between the duplicated configuration copies raises `irq_hi_o` in the cycle after the divergent write and pulls the pin low in the cycle after that. The state register then exposes the mismatch bit for software to read.

// File: rtl/seh_pkg.sv
package seh_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned BANK_W = 3;

  typedef enum logic [BANK_W-1:0] {
    BANK_GLB  = 3'd0,
    BANK_MODE = 3'd1,
    BANK_PRIO = 3'd2,
    BANK_EN   = 3'd3,
    BANK_STAT = 3'd4
  } bank_e;

  localparam int unsigned GLB_CTRL   = 0;
  localparam int unsigned GLB_PINMIN = 1;
  localparam int unsigned GLB_STATE  = 2;

  typedef struct packed {
    logic shadow_hold;
    logic force_lo;
    logic force_hi;
  } ctrl_t;
endpackage

// File: rtl/seh_dup_reg.sv
module seh_dup_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic         hold_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         mismatch_o
);
  logic [W-1:0] pri_q, sha_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_q <= RST_VAL;
      sha_q <= RST_VAL;
    end else if (we_i) begin
      pri_q <= d_i;
      if (!hold_i) sha_q <= d_i;
    end
  end

  assign q_o        = pri_q;
  assign mismatch_o = (pri_q != sha_q);

  assert_refresh_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hold_i) |=> !mismatch_o);

  assert_diverge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mismatch_o) |-> $past(we_i && hold_i));
endmodule

// File: rtl/seh_evt_capture.sv
module seh_evt_capture #(
  parameter int unsigned NUM_EVT = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] pulse_i,
  input  logic [NUM_EVT-1:0] clr_i,
  output logic [NUM_EVT-1:0] status_o
);
  logic [NUM_EVT-1:0] st_q;

  // pulse: sticky, set wins over clear; level: follows input
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= (pulse_i & ((st_q & ~clr_i) | evt_i)) | (~pulse_i & evt_i);
  end

  assign status_o = st_q;

  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q & $past(st_q & pulse_i & ~clr_i)) == $past(st_q & pulse_i & ~clr_i)));

  assert_level_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q & ~$past(pulse_i)) == ($past(evt_i) & ~$past(pulse_i))));
endmodule

// File: rtl/seh_pin_timer.sv
module seh_pin_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_i,
  input  logic [CNT_W-1:0] min_i,
  output logic             active_o
);
  logic             act_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (!act_q) begin
      if (err_i) begin
        act_q <= 1'b1;
        cnt_q <= min_i;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (!err_i) begin
      act_q <= 1'b0;
    end
  end

  assign active_o = act_q;

  // checker-only: cycles held versus minimum latched at assertion
  logic [CNT_W:0]   held_q;
  logic [CNT_W-1:0] min_lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q    <= '0;
      min_lat_q <= '0;
    end else if (!act_q && err_i) begin
      held_q    <= (CNT_W+1)'(1);
      min_lat_q <= min_i;
    end else if (act_q && held_q != '1) begin
      held_q    <= held_q + 1'b1;
    end
  end

  assert_engage_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !act_q) |=> act_q);

  assert_min_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_q) |-> (held_q > {1'b0, min_lat_q}));
endmodule

// File: rtl/safety_err_hub.sv
module safety_err_hub
  import seh_pkg::*;
#(
  parameter int unsigned NUM_EVT = 64,
  parameter int unsigned CNT_W   = 16,
  parameter logic [CNT_W-1:0] PIN_MIN_RST = CNT_W'(8),
  localparam int unsigned NUM_WORDS = NUM_EVT / REG_W,
  localparam int unsigned IDX_W  = ($clog2(NUM_WORDS) > 2) ? $clog2(NUM_WORDS) : 2,
  localparam int unsigned ADDR_W = BANK_W + IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               irq_hi_o,
  output logic               irq_lo_o,
  output logic               err_pin_no
);
  bank_e              bank;
  logic [IDX_W-1:0]   widx;
  logic               wr_glb;
  ctrl_t              ctrl_q;
  logic [CNT_W-1:0]   pin_min;
  logic               pin_min_mm;
  logic [NUM_EVT-1:0] pulse_q, prio, en, clr, status;
  logic [NUM_WORDS-1:0] prio_mm, en_mm;
  logic               cfg_err, hi_err, lo_err, pin_act;

  assign bank   = bank_e'(reg_addr_i[ADDR_W-1:IDX_W]);
  assign widx   = reg_addr_i[IDX_W-1:0];
  assign wr_glb = reg_we_i && (bank == BANK_GLB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_glb && widx == IDX_W'(GLB_CTRL)) ctrl_q <= ctrl_t'(reg_wdata_i[2:0]);
  end

  seh_dup_reg #(.W(CNT_W), .RST_VAL(PIN_MIN_RST)) u_pin_min (
    .clk_i, .rst_ni,
    .we_i      (wr_glb && widx == IDX_W'(GLB_PINMIN)),
    .hold_i    (ctrl_q.shadow_hold),
    .d_i       (reg_wdata_i[CNT_W-1:0]),
    .q_o       (pin_min),
    .mismatch_o(pin_min_mm)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic sel;
    logic [REG_W-1:0] mode_q;
    assign sel = (widx == IDX_W'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mode_q <= '0;
      else if (reg_we_i && bank == BANK_MODE && sel) mode_q <= reg_wdata_i;
    end
    assign pulse_q[w*REG_W +: REG_W] = mode_q;

    seh_dup_reg #(.W(REG_W)) u_prio (
      .clk_i, .rst_ni,
      .we_i      (reg_we_i && bank == BANK_PRIO && sel),
      .hold_i    (ctrl_q.shadow_hold),
      .d_i       (reg_wdata_i),
      .q_o       (prio[w*REG_W +: REG_W]),
      .mismatch_o(prio_mm[w])
    );

    seh_dup_reg #(.W(REG_W)) u_en (
      .clk_i, .rst_ni,
      .we_i      (reg_we_i && bank == BANK_EN && sel),
      .hold_i    (ctrl_q.shadow_hold),
      .d_i       (reg_wdata_i),
      .q_o       (en[w*REG_W +: REG_W]),
      .mismatch_o(en_mm[w])
    );

    assign clr[w*REG_W +: REG_W] = (reg_we_i && bank == BANK_STAT && sel) ? reg_wdata_i : '0;
  end

  seh_evt_capture #(.NUM_EVT(NUM_EVT)) u_cap (
    .clk_i, .rst_ni,
    .evt_i   (evt_i),
    .pulse_i (pulse_q),
    .clr_i   (clr),
    .status_o(status)
  );

  assign cfg_err = pin_min_mm | (|prio_mm) | (|en_mm);
  assign hi_err  = (|(status & en & prio))  | ctrl_q.force_hi | cfg_err;
  assign lo_err  = (|(status & en & ~prio)) | ctrl_q.force_lo;

  seh_pin_timer #(.CNT_W(CNT_W)) u_pin (
    .clk_i, .rst_ni,
    .err_i   (hi_err),
    .min_i   (pin_min),
    .active_o(pin_act)
  );

  assign irq_hi_o   = hi_err;
  assign irq_lo_o   = lo_err;
  assign err_pin_no = ~pin_act;

  always_comb begin
    reg_rdata_o = '0;
    case (bank)
      BANK_GLB: begin
        if (widx == IDX_W'(GLB_CTRL))   reg_rdata_o = {29'b0, ctrl_q};
        if (widx == IDX_W'(GLB_PINMIN)) reg_rdata_o = REG_W'(pin_min);
        if (widx == IDX_W'(GLB_STATE))  reg_rdata_o = {28'b0, lo_err, hi_err, cfg_err, pin_act};
      end
      BANK_MODE: for (int w = 0; w < NUM_WORDS; w++)
        if (widx == IDX_W'(w)) reg_rdata_o = pulse_q[w*REG_W +: REG_W];
      BANK_PRIO: for (int w = 0; w < NUM_WORDS; w++)
        if (widx == IDX_W'(w)) reg_rdata_o = prio[w*REG_W +: REG_W];
      BANK_EN: for (int w = 0; w < NUM_WORDS; w++)
        if (widx == IDX_W'(w)) reg_rdata_o = en[w*REG_W +: REG_W];
      BANK_STAT: for (int w = 0; w < NUM_WORDS; w++)
        if (widx == IDX_W'(w)) reg_rdata_o = status[w*REG_W +: REG_W];
      default: reg_rdata_o = '0;
    endcase
  end

  assert_pin_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hi_o |=> !err_pin_no);
endmodule

// File: tb/safety_err_hub_tb.sv
module safety_err_hub_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NEVT = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NEVT-1:0] evt = '0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_hi, irq_lo, pin_n;
  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  safety_err_hub #(.NUM_EVT(NEVT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_hi_o(irq_hi), .irq_lo_o(irq_lo), .err_pin_no(pin_n)
  );

  function automatic logic [4:0] ra(int bank, int idx);
    return {bank[2:0], idx[1:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int bank, int idx, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = ra(bank, idx); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(int bank, int idx, output logic [31:0] d);
    addr = ra(bank, idx);
    #1 d = rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      if (pin_n === 1'b1 && irq_hi === 1'b0) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R10 pin", {31'b0, pin_n}, 1);
    chk("R10 irq_hi", {31'b0, irq_hi}, 0);
    chk("R10 irq_lo", {31'b0, irq_lo}, 0);
    rd(0, 1, d); chk("R10 pin_min", d, 8);
    rd(0, 0, d); chk("R10 ctrl", d, 0);
    rd(3, 1, d); chk("R10 enable", d, 0);
    wr(0, 1, 2);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(3, 0, 32'h8);
    @(negedge clk); evt[3] = 1'b1;
    @(negedge clk);
    rd(4, 0, d); chk("R1 level set", d, 32'h8);
    chk("R3 lo path", {31'b0, irq_lo}, 1);
    wr(4, 0, 32'h8);
    rd(4, 0, d); chk("R1 w1c ignored", d, 32'h8);
    evt[3] = 1'b0;
    @(negedge clk);
    rd(4, 0, d); chk("R1 level follows", d, 0);
    chk("R1 irq_lo drop", {31'b0, irq_lo}, 0);
    wr(3, 0, 0);
  endtask

  task automatic t_pulse();
    logic [31:0] d;
    wr(1, 0, 32'h20); wr(3, 0, 32'h20);
    @(negedge clk); evt[5] = 1'b1;
    @(negedge clk); evt[5] = 1'b0;
    repeat (3) @(negedge clk);
    rd(4, 0, d); chk("R2 sticky", d, 32'h20);
    chk("R2 irq_lo", {31'b0, irq_lo}, 1);
    wr(4, 0, 32'h20);
    rd(4, 0, d); chk("R2 clear", d, 0);
    chk("R2 irq_lo clear", {31'b0, irq_lo}, 0);
    @(negedge clk);
    evt[5] = 1'b1; we = 1'b1; addr = ra(4, 0); wdata = 32'h20;
    @(negedge clk);
    we = 1'b0; evt[5] = 1'b0;
    rd(4, 0, d); chk("R2 set wins", d, 32'h20);
    wr(4, 0, 32'h20);
    wr(1, 0, 0); wr(3, 0, 0);
  endtask

  task automatic t_prio();
    wr(3, 1, 32'h4); wr(2, 1, 32'h4);
    @(negedge clk); evt[34] = 1'b1;
    @(negedge clk);
    chk("R3 hi path", {31'b0, irq_hi}, 1);
    chk("R3 hi not lo", {31'b0, irq_lo}, 0);
    wr(2, 1, 0);
    chk("R3 moved hi off", {31'b0, irq_hi}, 0);
    chk("R3 moved lo on", {31'b0, irq_lo}, 1);
    evt[34] = 1'b0;
    @(negedge clk);
    chk("R3 lo off", {31'b0, irq_lo}, 0);
    wr(3, 1, 0);
    wait_idle();
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(2, 0, 32'h80);
    @(negedge clk); evt[7] = 1'b1;
    @(negedge clk);
    rd(4, 0, d); chk("R4 raw kept", d, 32'h80);
    chk("R4 hi masked", {31'b0, irq_hi}, 0);
    chk("R4 lo masked", {31'b0, irq_lo}, 0);
    @(negedge clk);
    chk("R4 pin masked", {31'b0, pin_n}, 1);
    wr(3, 0, 32'h80);
    chk("R4 unmasked", {31'b0, irq_hi}, 1);
    evt[7] = 1'b0;
    wr(3, 0, 0); wr(2, 0, 0);
    wait_idle();
  endtask

  task automatic t_pin();
    int cnt;
    wr(0, 1, 5);
    wr(3, 0, 32'h400); wr(2, 0, 32'h400);
    @(negedge clk); evt[10] = 1'b1;
    @(negedge clk);
    chk("R5 irq first", {31'b0, irq_hi}, 1);
    chk("R5 pin not yet", {31'b0, pin_n}, 1);
    @(negedge clk);
    chk("R5 pin low", {31'b0, pin_n}, 0);
    evt[10] = 1'b0;
    cnt = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pin_n !== 1'b0) break;
      cnt++;
    end
    chk("R6 min width", cnt, 6);
    wr(0, 1, 2);
    @(negedge clk); evt[10] = 1'b1;
    repeat (10) @(negedge clk);
    chk("R6 held by cause", {31'b0, pin_n}, 0);
    evt[10] = 1'b0;
    @(negedge clk);
    chk("R6 still held", {31'b0, pin_n}, 0);
    @(negedge clk);
    chk("R6 released", {31'b0, pin_n}, 1);
    wr(3, 0, 0); wr(2, 0, 0);
  endtask

  task automatic t_force();
    wr(0, 0, 1);
    chk("R7 force hi irq", {31'b0, irq_hi}, 1);
    @(negedge clk);
    chk("R7 force pin", {31'b0, pin_n}, 0);
    wr(0, 0, 2);
    chk("R7 force lo", {31'b0, irq_lo}, 1);
    chk("R7 hi off", {31'b0, irq_hi}, 0);
    wr(0, 0, 0);
    chk("R7 lo off", {31'b0, irq_lo}, 0);
    wait_idle();
  endtask

  task automatic t_dup();
    logic [31:0] d;
    wr(0, 0, 4);
    wr(3, 1, 32'hFFFF_FFFF);
    rd(0, 2, d); chk("R8 mismatch flag", d & 32'h6, 32'h6);
    chk("R8 irq_hi", {31'b0, irq_hi}, 1);
    @(negedge clk);
    chk("R8 pin", {31'b0, pin_n}, 0);
    wr(0, 0, 0);
    wr(3, 1, 32'hFFFF_FFFF);
    rd(0, 2, d); chk("R8 agree", d & 32'h2, 0);
    wr(3, 1, 0);
    chk("R8 irq off", {31'b0, irq_hi}, 0);
    wait_idle();
  endtask

  task automatic t_words();
    logic [31:0] d;
    wr(1, 1, 32'h8000_0000);
    rd(1, 1, d); chk("R9 word1 mode", d, 32'h8000_0000);
    rd(1, 0, d); chk("R9 word0 mode", d, 0);
    @(negedge clk); evt[63] = 1'b1;
    @(negedge clk); evt[63] = 1'b0;
    @(negedge clk);
    rd(4, 1, d); chk("R9 word1 status", d, 32'h8000_0000);
    rd(4, 0, d); chk("R9 word0 status", d, 0);
    wr(4, 1, 32'h8000_0000);
    rd(4, 1, d); chk("R9 word1 cleared", d, 0);
    wr(1, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_level();
    t_pulse();
    t_prio();
    t_mask();
    t_pin();
    t_force();
    t_dup();
    t_words();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule